// File: doc/BRIEF.md
# Periodic Interrupt Timer with Sticky Flag

A free-running counter repeatedly counts from zero up to a programmed period and wraps. Each wrap is a period match, and it sets an interrupt flag that drives the single interrupt request line. By default the flag is sticky and stays high until software writes a one to its clear bit. A match that arrives while the flag is still high therefore gives the interrupt controller no new rising edge, and a separate overrun bit records that this happened.

An optional hardware auto-clear drops the flag a programmed number of cycles after it was raised. The request line then becomes a train of pulses, one for each period, and an edge-sensitive interrupt input sees every period. Software reaches the block through a small word-wide register port with synchronous writes and reads that return one cycle later.

Top module: `sticky_tick_timer`

## Requirements
- R1: While running, the counter steps from 0 to PERIOD-1 and wraps. The match occurs in the cycle where the count equals PERIOD-1. The flag, and with it `irq`, goes high exactly PERIOD cycles after the clock edge that set the run bit, and again every PERIOD cycles after that.
- R2: `irq` always equals the flag. With auto-clear off, a set flag stays high until software clears it.
- R3: A match while the flag is already high causes no new rising edge on `irq` and sets the overrun bit (STATUS bit 1).
- R4: With auto-clear on (CTRL bit 1) and a delay D where 1 <= D < PERIOD, each match raises `irq` for exactly D cycles.
- R5: With auto-clear on and a delay of 0, or a delay >= PERIOD, the flag is held exactly as in R2.
- R6: A write of 1 to STATUS bit 0 (address 3) clears the flag from the next cycle. A write of 0 to that bit leaves the flag unchanged.
- R7: When a clear write and a match fall in the same cycle, the match wins and the flag stays set.
- R8: Writing 0 to the run bit (CTRL bit 0, address 0) stops the counter and returns it to zero without touching the flag. A later run restarts the count from zero.
- R9: A write of 1 to STATUS bit 1 clears the overrun bit and leaves the flag unchanged.
- R10: After reset CTRL reads 0, PERIOD (address 1) reads PERIOD_RST, DELAY (address 2) reads 1, STATUS reads 0 and `irq` is low.
- R11: `rd_data` presents the register selected by `rd_addr` one clock after that address is applied. Fields are right-aligned with zeros above them, and STATUS bit 0 shows the current flag at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 CTRL, 1 PERIOD, 2 DELAY, 3 STATUS |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt request (the flag) |

## Verification
The bench goes after a clear write that lands in the same cycle as a match. A design that gives the clear priority would drop a period's interrupt there. It checks that a write of zero to the status bits changes nothing, and that clearing the overrun leaves the flag alone. It also checks that stopping the timer restarts the count from zero: a counter that only paused would fire early after the restart. A table of settings covers auto-clear delays of one cycle, of one less than the period, of zero and of exactly the period. A design that compared the delay wrongly would either hold the flag where it should pulse or pulse where it should hold, and that shows in the edge and high-cycle counts.

// File: rtl/stt_pkg.sv
package stt_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 2'd0,
    A_PERIOD = 2'd1,
    A_DELAY  = 2'd2,
    A_STATUS = 2'd3
  } reg_addr_e;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_AUTO = 1;
  localparam int ST_FLAG   = 0;
  localparam int ST_OVR    = 1;
endpackage

// File: rtl/stt_regs.sv
module stt_regs
  import stt_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int DLY_W      = 8,
  parameter int PERIOD_RST = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              flag,
  input  logic              ovr,
  output logic              run,
  output logic              auto_en,
  output logic [CNT_W-1:0]  period,
  output logic [DLY_W-1:0]  dly,
  output logic              clr_flag,
  output logic              clr_ovr
);
  localparam logic [CNT_W-1:0] PERIOD_INIT = CNT_W'(PERIOD_RST);

  logic              status_wr;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wr;

  assign unused_wr = ^wr_data;
  assign status_wr = wr_en && (wr_addr == A_STATUS);
  assign clr_flag  = status_wr && wr_data[ST_FLAG];
  assign clr_ovr   = status_wr && wr_data[ST_OVR];

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      auto_en <= 1'b0;
      period  <= PERIOD_INIT;
      dly     <= DLY_W'(1);
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          run     <= wr_data[CTRL_RUN];
          auto_en <= wr_data[CTRL_AUTO];
        end
        A_PERIOD: period <= wr_data[CNT_W-1:0];
        A_DELAY:  dly    <= wr_data[DLY_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_mux[CTRL_RUN]  = run;
        rd_mux[CTRL_AUTO] = auto_en;
      end
      A_PERIOD: rd_mux[CNT_W-1:0] = period;
      A_DELAY:  rd_mux[DLY_W-1:0] = dly;
      default: begin
        rd_mux[ST_FLAG] = flag;
        rd_mux[ST_OVR]  = ovr;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  // R11: a status read shows the flag one cycle after the address was applied
  a_r11_status_read: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == A_STATUS) |=> (rd_data[ST_FLAG] == $past(flag)));
endmodule

// File: rtl/stt_count.sv
module stt_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  output logic             match
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  // A period of zero wraps at the full counter range
  assign last  = period - 1'b1;
  assign match = run && (cnt >= last);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (match)  cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  a_r8_stop_zero: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));
  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    match |=> (cnt == '0));
endmodule

// File: rtl/stt_flag.sv
module stt_flag #(
  parameter int CNT_W = 16,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             match,
  input  logic             clr_flag,
  input  logic             clr_ovr,
  input  logic             auto_en,
  input  logic [DLY_W-1:0] dly,
  input  logic [CNT_W-1:0] period,
  output logic             flag,
  output logic             ovr
);
  logic [DLY_W-1:0] age;
  logic             ac_ok;

  // Auto-clear only when the delay is nonzero and shorter than the period
  assign ac_ok = auto_en && (dly != '0) &&
                 ((period == '0) || (CNT_W'(dly) < period));

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      age  <= '0;
    end else if (match) begin
      flag <= 1'b1;
      age  <= DLY_W'(1);
    end else if (clr_flag) begin
      flag <= 1'b0;
    end else if (flag && ac_ok && (age >= dly)) begin
      flag <= 1'b0;
    end else if (flag && (age != '1)) begin
      age <= age + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                ovr <= 1'b0;
    else if (match && flag) ovr <= 1'b1;
    else if (clr_ovr)       ovr <= 1'b0;
  end

  a_r7_match_wins: assert property (@(posedge clk) disable iff (rst)
    match |=> flag);
  a_r3_overrun: assert property (@(posedge clk) disable iff (rst)
    (match && flag) |=> ovr);
  a_r3_edge_from_match: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(match));
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag && !match && !clr_flag && !ac_ok) |=> flag);
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_flag && !match) |=> !flag);
  a_r4_autoclear: assert property (@(posedge clk) disable iff (rst)
    (flag && ac_ok && !match && (age == dly)) |=> !flag);
endmodule

// File: rtl/sticky_tick_timer.sv
module sticky_tick_timer
  import stt_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int DLY_W      = 8,
  parameter int PERIOD_RST = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic             run, auto_en, clr_flag, clr_ovr, match, flag, ovr;
  logic [CNT_W-1:0] period;
  logic [DLY_W-1:0] dly;

  stt_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .DLY_W(DLY_W), .PERIOD_RST(PERIOD_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .flag(flag), .ovr(ovr), .run(run), .auto_en(auto_en),
    .period(period), .dly(dly), .clr_flag(clr_flag), .clr_ovr(clr_ovr)
  );

  stt_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .run(run), .period(period), .match(match)
  );

  stt_flag #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_flag (
    .clk(clk), .rst(rst), .match(match), .clr_flag(clr_flag),
    .clr_ovr(clr_ovr), .auto_en(auto_en), .dly(dly), .period(period),
    .flag(flag), .ovr(ovr)
  );

  assign irq = flag;

  a_r8_flag_kept_on_stop: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr_flag && !(auto_en && dly != '0)) |=> (flag == $past(flag)));
endmodule

// File: tb/sticky_tick_timer_tb.sv
`timescale 1ns/1ps
module sticky_tick_timer_tb;
  import stt_pkg::*;
  localparam int DATA_W = 32;
  localparam int PRST   = 1000;
  localparam int NV     = 7;
  // period, delay, auto-clear, expected rising edges, expected high samples
  localparam int V_P[NV]  = '{5, 8, 10, 6, 4, 7, 12};
  localparam int V_D[NV]  = '{2, 1,  7, 0, 4, 3, 11};
  localparam int V_A[NV]  = '{1, 1,  1, 1, 1, 0,  1};
  localparam int V_R[NV]  = '{4, 4,  4, 1, 1, 1,  4};
  localparam int V_H[NV]  = '{7, 4, 22, 19, 13, 22, 34};

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, irq;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] wr_data = '0, rd_data;
  int n_chk = 0, n_bad = 0, v;

  always #2.5 clk = ~clk;

  sticky_tick_timer #(.DATA_W(DATA_W), .PERIOD_RST(PRST)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = DATA_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int val);
    rd_addr = a;
    @(negedge clk);
    val = int'(rd_data);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R10 reset state, read through R11 port timing
    chk("R10 irq", int'(irq), 0);
    rd(A_CTRL, v);   chk("R10 ctrl", v, 0);
    rd(A_PERIOD, v); chk("R10 period R11", v, PRST);
    rd(A_DELAY, v);  chk("R10 delay", v, 1);
    rd(A_STATUS, v); chk("R10 status", v, 0);

    // Table walk: R1, R2, R3, R4, R5
    for (int i = 0; i < NV; i++) begin
      int rises, highs, prev;
      string tag;
      wr(A_PERIOD, V_P[i]);
      wr(A_DELAY, V_D[i]);
      wr(A_CTRL, 1 | (V_A[i] << 1));
      prev = 0; rises = 0; highs = 0;
      for (int j = 1; j <= 4 * V_P[i]; j++) begin
        step(1);
        if (irq && !prev) rises++;
        if (irq) highs++;
        prev = int'(irq);
      end
      if (V_A[i] == 1 && V_D[i] >= 1 && V_D[i] < V_P[i]) tag = "R4";
      else if (V_A[i] == 1) tag = "R5";
      else tag = "R2";
      chk({tag, " high cycles"}, highs, V_H[i]);
      chk("R3 rising edges", rises, V_R[i]);
      rd(A_STATUS, v);
      chk("R3 overrun bit", (v >> 1) & 1, (V_R[i] == 1) ? 1 : 0);
      wr(A_CTRL, 0);
      wr(A_STATUS, 3);
    end

    // Directed: clear versus match, write of zero, overrun clear
    wr(A_PERIOD, 6);
    wr(A_DELAY, 1);
    wr(A_CTRL, 1);                       // edge W, now j=0
    step(5);  chk("R1 before match", int'(irq), 0);
    step(1);  chk("R1 first match", int'(irq), 1);
    step(5);                              // j=11
    wr(A_STATUS, 1);                      // lands on match edge W+12
    chk("R7 match wins", int'(irq), 1);
    rd(A_STATUS, v);                      // j=13
    chk("R3 overrun with flag", v, 3);
    wr(A_STATUS, 0);                      // j=14
    chk("R6 zero write ignored", int'(irq), 1);
    wr(A_STATUS, 1);                      // j=15
    chk("R6 clear", int'(irq), 0);
    step(2);
    chk("R6 stays clear", int'(irq), 0);
    step(1);                              // j=18
    chk("R1 next period", int'(irq), 1);
    wr(A_STATUS, 2);                      // j=19
    rd(A_STATUS, v);                      // j=20
    chk("R9 overrun cleared flag kept", v, 1);

    // Directed: stop keeps flag, restart from zero
    wr(A_CTRL, 0);
    step(10);
    chk("R8 flag kept while stopped", int'(irq), 1);
    wr(A_STATUS, 1);
    chk("R8 cleared while stopped", int'(irq), 0);
    wr(A_CTRL, 1);
    step(5);
    chk("R8 restart no early match", int'(irq), 0);
    step(1);
    chk("R8 restart from zero", int'(irq), 1);
    rd(A_CTRL, v);
    chk("R11 ctrl readback", v, 1);
    wr(A_CTRL, 0);
    wr(A_STATUS, 3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule